// File: doc/BRIEF.md
# Configuration Memory Security Lock

This block guards a serial configuration memory against readout and tampering. It watches the write and read strobes that the bus protocol engine has already decoded, and it reacts to a small reserved window of four byte addresses. The block keeps a lock flag that stands in for the non-volatile security fuse. Writing an all-ones byte to each of the four reserved addresses, in ascending order, sets the lock. While the lock is set, the block withholds the readback and programming enables that the rest of the memory controller uses to gate external access.

The lock clears only when the all-zero byte pattern is written to the same four addresses in two complete passes within one power session. Clearing always starts a timed erase of the whole array, and the block ignores the bus while that erase runs. A power-cycle input discards any unlock progress and leaves the lock flag untouched. A read of a reserved address returns a status byte: all ones when the array is locked, all zeros when it is not.

Top module: `cfglock_guard`

## Requirements
- R1: After reset, `locked` is 0, `rdback_en` and `prog_en` are 1, and `erase_req`, `erase_busy` and `rd_vld` are 0.
- R2: Four accepted writes of 0xFF to offsets 0, 1, 2 and 3 of the reserved window (KEY_BASE = 0x800000 to 0x800003), in that order, set `locked`. The flag rises two clock cycles after the strobe of the last write.
- R3: While `locked` is 1, both `rdback_en` and `prog_en` are 0.
- R4: A read strobe to a reserved address gives `rd_vld` = 1 one cycle later. The accompanying `rd_data` is 0xFF when locked and 0x00 when unlocked. A read strobe to any other address leaves `rd_vld` at 0.
- R5: One complete pass of 0x00 to offsets 0..3 leaves the lock set. A second complete pass in the same power session clears `locked`.
- R6: When the lock is cleared, `erase_req` pulses for exactly one cycle. `erase_busy` goes high in the same cycle that `locked` falls and stays high for exactly ERASE_CYCLES cycles.
- R7: While `erase_busy` is 1, read and write strobes are ignored: no `rd_vld` is produced, no pattern progress is made, and `prog_en` is 0.
- R8: A `pwr_cycle` pulse discards any completed zero-pattern passes and keeps `locked` unchanged.
- R9: A write to the reserved window that breaks the pattern cancels all pattern progress, including earlier completed zero-pattern passes. Breaking the pattern means any of: an offset other than the next expected one, a byte other than 0x00 or 0xFF, or a byte that differs from the first byte of the current pass.
- R10: Two complete zero-pattern passes start the erase of R6 even when the block is already unlocked; `locked` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; initialises the modelled fuse to unlocked |
| pwr_cycle | input | 1 | Power-session restart event; clears unlock progress |
| wr_stb | input | 1 | One-cycle write strobe from the protocol engine |
| rd_stb | input | 1 | One-cycle read strobe from the protocol engine |
| addr | input | 24 | Byte address of the current access |
| wdata | input | 8 | Write byte |
| locked | output | 1 | Security lock flag |
| rdback_en | output | 1 | High when external data readback may proceed |
| prog_en | output | 1 | High when normal array programming may proceed |
| erase_req | output | 1 | One-cycle request to start the full-array erase |
| erase_busy | output | 1 | High while the timed erase runs |
| rd_data | output | 8 | Status byte for a reserved-address read |
| rd_vld | output | 1 | Qualifies `rd_data` |

## Verification
The assertions assume three things about the inputs. Strobes are single-cycle pulses. A read and a write never coincide. A `pwr_cycle` pulse does not land inside a pattern pass that the stimulus expects to complete. The stimulus meets these assumptions by driving every access from tasks that raise a strobe for exactly one cycle, with a full cycle of idle between accesses. It also waits several cycles after the final byte of a pass before it issues a power-cycle or a read. The accesses that fall inside an erase are issued only once `erase_busy` has been seen high, so that none of them slips into the gap between the unlock decision and the start of the erase.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;
  // Pattern class of the pass currently being collected.
  typedef enum logic [1:0] {
    PAT_NONE  = 2'd0,
    PAT_ONES  = 2'd1,
    PAT_ZEROS = 2'd2
  } pat_e;
endpackage

// File: rtl/cfglock_decode.sv
module cfglock_decode #(
  parameter int          ADDR_W    = 24,
  parameter logic [23:0] KEY_BASE  = 24'h800000,
  parameter int          KEY_BYTES = 4,
  localparam int         IDX_W     = $clog2(KEY_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_key,
  output logic [IDX_W-1:0]  key_off
);
  logic [KEY_BYTES-1:0] hit;

  // One comparator per reserved byte.
  for (genvar k = 0; k < KEY_BYTES; k++) begin : g_hit
    assign hit[k] = (addr == ADDR_W'(KEY_BASE) + ADDR_W'(k));
  end

  assign in_key = |hit;

  always_comb begin
    key_off = '0;
    for (int k = 0; k < KEY_BYTES; k++) begin
      if (hit[k]) key_off = IDX_W'(k);
    end
  end
endmodule

// File: rtl/cfglock_track.sv
module cfglock_track
  import cfglock_pkg::*;
#(
  parameter int  DATA_W        = 8,
  parameter int  KEY_BYTES     = 4,
  parameter int  UNLOCK_PASSES = 2,
  localparam int IDX_W         = $clog2(KEY_BYTES),
  localparam int PASS_W        = $clog2(UNLOCK_PASSES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              key_wr,
  input  logic [IDX_W-1:0]  key_off,
  input  logic [DATA_W-1:0] wdata,
  output logic              set_p,
  output logic              clr_p
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(KEY_BYTES - 1);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(UNLOCK_PASSES - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [PASS_W-1:0] pass_q;
  pat_e              kind_q;
  pat_e              byte_kind;
  logic              step_ok;

  always_comb begin
    if (wdata == {DATA_W{1'b1}})      byte_kind = PAT_ONES;
    else if (wdata == {DATA_W{1'b0}}) byte_kind = PAT_ZEROS;
    else                              byte_kind = PAT_NONE;
    step_ok = (key_off == idx_q) && (byte_kind != PAT_NONE) &&
              ((idx_q == '0) || (byte_kind == kind_q));
  end

  always_ff @(posedge clk) begin
    set_p <= 1'b0;
    clr_p <= 1'b0;
    if (rst || pwr_cycle) begin
      idx_q  <= '0;
      pass_q <= '0;
      kind_q <= PAT_NONE;
    end else if (key_wr) begin
      if (!step_ok) begin
        idx_q  <= '0;
        pass_q <= '0;
        kind_q <= PAT_NONE;
      end else if (idx_q == LAST_IDX) begin
        idx_q  <= '0;
        kind_q <= PAT_NONE;
        if (byte_kind == PAT_ONES) begin
          set_p  <= 1'b1;
          pass_q <= '0;
        end else if (pass_q == LAST_PASS) begin
          clr_p  <= 1'b1;
          pass_q <= '0;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end else begin
        idx_q  <= idx_q + 1'b1;
        kind_q <= byte_kind;
      end
    end
  end

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(set_p && clr_p));

  // R8
  pwr_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle |=> (!set_p && !clr_p));
endmodule

// File: rtl/cfglock_erase.sv
module cfglock_erase #(
  parameter int  ERASE_CYCLES = 3125000,
  localparam int CNT_W        = $clog2(ERASE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic req,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      req <= start && !busy;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt_q <= CNT_W'(ERASE_CYCLES - 1);
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R6
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (busy && !$past(busy)));

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
endmodule

// File: rtl/cfglock_guard.sv
module cfglock_guard #(
  parameter int          ADDR_W        = 24,
  parameter int          DATA_W        = 8,
  parameter logic [23:0] KEY_BASE      = 24'h800000,
  parameter int          KEY_BYTES     = 4,
  parameter int          UNLOCK_PASSES = 2,
  parameter int          ERASE_CYCLES  = 3125000,
  localparam int         IDX_W         = $clog2(KEY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              rdback_en,
  output logic              prog_en,
  output logic              erase_req,
  output logic              erase_busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  logic             in_key;
  logic [IDX_W-1:0] key_off;
  logic             set_p, clr_p;
  logic             key_wr, key_rd;

  cfglock_decode #(
    .ADDR_W(ADDR_W), .KEY_BASE(KEY_BASE), .KEY_BYTES(KEY_BYTES)
  ) u_dec (
    .addr(addr), .in_key(in_key), .key_off(key_off)
  );

  assign key_wr = wr_stb && in_key && !erase_busy;
  assign key_rd = rd_stb && in_key && !erase_busy;

  cfglock_track #(
    .DATA_W(DATA_W), .KEY_BYTES(KEY_BYTES), .UNLOCK_PASSES(UNLOCK_PASSES)
  ) u_trk (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .key_wr(key_wr),
    .key_off(key_off), .wdata(wdata), .set_p(set_p), .clr_p(clr_p)
  );

  cfglock_erase #(.ERASE_CYCLES(ERASE_CYCLES)) u_ers (
    .clk(clk), .rst(rst), .start(clr_p), .req(erase_req), .busy(erase_busy)
  );

  // Modelled fuse: only reset (factory state) or a completed pattern moves it.
  always_ff @(posedge clk) begin
    if (rst)        locked <= 1'b0;
    else if (clr_p) locked <= 1'b0;
    else if (set_p) locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= key_rd;
      if (key_rd) rd_data <= {DATA_W{locked}};
    end
  end

  assign rdback_en = !locked;
  assign prog_en   = !locked && !erase_busy;

  // R6
  unlock_erase_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> erase_busy);

  // R4
  rd_value_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> (rd_data == {DATA_W{1'b1}} || rd_data == {DATA_W{1'b0}}));

  // R7
  busy_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (erase_busy && $past(erase_busy)) |=> !rd_vld);
endmodule

// File: tb/cfglock_guard_tb.sv
module cfglock_guard_tb;
  localparam int          ERASE_N = 40;
  localparam logic [23:0] BASE    = 24'h800000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_cycle = 1'b0;
  logic        wr_stb = 1'b0;
  logic        rd_stb = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        locked, rdback_en, prog_en, erase_req, erase_busy, rd_vld;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  int busy_cnt = 0;
  int req_cnt = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  cfglock_guard #(.ERASE_CYCLES(ERASE_N)) u_dut (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .addr(addr), .wdata(wdata), .locked(locked),
    .rdback_en(rdback_en), .prog_en(prog_en), .erase_req(erase_req),
    .erase_busy(erase_busy), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for read results plus erase bookkeeping.
  always @(negedge clk) begin
    if (!rst) begin
      if (erase_busy) busy_cnt++;
      if (erase_req)  req_cnt++;
      if (rd_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected rd_vld", rd_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R4 read data", rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input bit expect_vld, input logic [7:0] e);
    @(negedge clk); rd_stb = 1'b1; addr = a;
    if (expect_vld) exp_q.push_back(e);
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic pass(input logic [7:0] d);
    for (int k = 0; k < 4; k++) wr(BASE + 24'(k), d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_erase_end();
    while (erase_busy) @(negedge clk);
    idle(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    // R1 reset state
    check(locked == 0, "R1 locked", locked, 0);
    check(rdback_en && prog_en, "R1 enables", {rdback_en, prog_en}, 3);
    check(!erase_req && !erase_busy && !rd_vld, "R1 idle", {erase_req, erase_busy, rd_vld}, 0);

    // R4 unlocked status read; read outside window yields nothing
    rd(BASE + 24'd2, 1'b1, 8'h00);
    rd(24'h000010, 1'b0, 8'h00);
    idle(2);

    // R2 lock via all-ones pass
    pass(8'hFF);
    idle(2);
    check(locked == 1, "R2 lock set", locked, 1);
    // R3 gates closed
    check(!rdback_en && !prog_en, "R3 gates", {rdback_en, prog_en}, 0);
    rd(BASE, 1'b1, 8'hFF);
    rd(BASE + 24'd3, 1'b1, 8'hFF);
    idle(2);

    // R5 single zero pass keeps lock
    pass(8'h00);
    idle(3);
    check(locked == 1 && req_cnt == 0, "R5 one pass", {locked, 4'(req_cnt)}, 16);

    // R8 power cycle drops progress, keeps lock
    @(negedge clk); pwr_cycle = 1'b1;
    @(negedge clk); pwr_cycle = 1'b0;
    idle(1);
    check(locked == 1, "R8 lock kept", locked, 1);
    pass(8'h00);
    idle(3);
    check(locked == 1 && req_cnt == 0, "R8 progress cleared", {locked, 4'(req_cnt)}, 16);

    // R9 wrong data breaks the sequence and drops the completed pass
    wr(BASE, 8'h00);
    wr(BASE + 24'd1, 8'h01);
    pass(8'h00);
    idle(3);
    check(locked == 1 && req_cnt == 0, "R9 bad byte", {locked, 4'(req_cnt)}, 16);

    // R5 / R6 two clean passes unlock and erase
    pass(8'h00);
    idle(2);
    check(locked == 0, "R5 unlocked", locked, 0);
    check(erase_busy == 1, "R6 busy with unlock", erase_busy, 1);
    // R7 accesses ignored during erase
    check(prog_en == 0, "R7 prog_en busy", prog_en, 0);
    rd(BASE, 1'b0, 8'h00);
    pass(8'hFF);
    wait_erase_end();
    check(req_cnt == 1, "R6 one request", req_cnt, 1);
    check(busy_cnt == ERASE_N, "R6 busy length", busy_cnt, ERASE_N);
    check(locked == 0, "R7 write ignored", locked, 0);
    check(prog_en && rdback_en, "R7 gates reopen", {prog_en, rdback_en}, 3);

    // R9 out-of-order offset aborts an all-ones pass
    wr(BASE, 8'hFF);
    wr(BASE + 24'd2, 8'hFF);
    wr(BASE + 24'd3, 8'hFF);
    idle(3);
    check(locked == 0, "R9 order", locked, 0);
    // R9 mixed pattern aborts
    wr(BASE, 8'h00);
    wr(BASE + 24'd1, 8'hFF);
    wr(BASE + 24'd2, 8'hFF);
    wr(BASE + 24'd3, 8'hFF);
    idle(3);
    check(locked == 0, "R9 mixed", locked, 0);

    // R10 erase from unlocked state
    pass(8'h00);
    pass(8'h00);
    idle(2);
    check(erase_busy == 1 && locked == 0, "R10 erase unlocked", {erase_busy, locked}, 2);
    wait_erase_end();
    check(req_cnt == 2, "R10 request count", req_cnt, 2);
    check(busy_cnt == 2 * ERASE_N, "R10 busy length", busy_cnt, 2 * ERASE_N);

    // R2 relock and R4 status read
    pass(8'hFF);
    idle(2);
    check(locked == 1, "R2 relock", locked, 1);
    rd(BASE + 24'd1, 1'b1, 8'hFF);
    idle(3);
    check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule